// File: doc/BRIEF.md
# SHA-512 Message Padder

This block sits in front of a SHA-512 compression engine and turns a byte-granular message into a stream of 1024-bit blocks. Message data arrives as 64-bit words over a valid/ready handshake. The earliest byte of each word is in bits [63:56]. A last flag marks the final word, and a byte count on that word tells how many of its leading bytes belong to the message. The block appends the 0x80 marker byte and the zero fill. It then closes the final block with a 128-bit big-endian bit-length field.

Blocks leave over a second valid/ready handshake, with a flag that marks the final block of the message. When the tail of the message leaves no room for the length field, the padder emits one extra block, all zeros apart from the length field. Input is stalled while a block waits to be taken. A new message is accepted only after the final block of the previous one has been handed off.

Top module: `sha512_pad_stream`

## Requirements
- R1: The first message byte appears in `out_block[1023:1016]`, and later bytes follow in falling bit order. Input words are big-endian: `in_data[63:56]` carries the earliest byte of the word.
- R2: Directly after the last valid message byte, the padded stream carries the byte 0x80. Bytes of the final input word at or beyond `in_bytes` are not passed through.
- R3: Every byte between the 0x80 marker and the length field is zero.
- R4: The last 16 bytes of the final block hold the message length in bits, most significant byte first. The upper 8 of those bytes are always zero.
- R5: If the message length modulo 128 bytes is 112 or more, the marker and zeros complete that block, and one further block of zeros ending in the length field follows.
- R6: A message of L bytes produces exactly ceil((L+17)/128) blocks. `out_final` is high on the last of them and low on all the others.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_block` and `out_final` hold their values.
- R8: `in_ready` is low from the cycle after the last word is accepted until the final block is handed off. It is also low whenever `out_valid` is high. After the final handoff it returns high, and the bit count restarts from zero.
- R9: `in_bytes` is ignored on words without `in_last`. On the last word it may be 0 to 8, where 0 means that word carries no message bytes. Values above 8 act as 8.
- R10: Reset (active-low `rst_n`) drops `out_valid`, raises `in_ready` and discards any partly received message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Padder can take a word |
| in_data | input | 64 | Message word, earliest byte in [63:56] |
| in_bytes | input | 4 | Valid leading bytes of the last word (0..8) |
| in_last | input | 1 | Word is the final one of the message |
| out_valid | output | 1 | Block offered |
| out_ready | input | 1 | Downstream takes the block |
| out_block | output | 1024 | Padded block, first byte in [1023:1016] |
| out_final | output | 1 | Block is the last of the message |

## Verification
The message lengths tried are 0, 1, 7, 8, 55, 111, 112, 119, 120, 127, 128, 129, 239 and 240 bytes. Together they separate the following cases:
- a marker that falls inside the last word from one that begins a fresh word;
- a tail that just fits the length field from one that needs the extra block;
- a message that ends exactly on a block edge from one that runs a byte past it.

Garbage placed in unused byte lanes and in the byte count of non-last words shows whether masking and count handling are correct. Stalled vectors hold back `out_ready` to expose a block that changes while it waits. A reset in the middle of a message, followed by a short message, shows whether the partial length is discarded.

// File: rtl/sha512_pad_pkg.sv
package sha512_pad_pkg;

   typedef enum logic [1:0] {
      PS_FILL = 2'd0,   // taking message words
      PS_TAIL = 2'd1,   // writing marker, zeros and length word by word
      PS_EMIT = 2'd2    // block offered downstream
   } pad_state_e;

   localparam logic [7:0] PAD_MARK = 8'h80;

endpackage

// File: rtl/pad_lane_merge.sv
module pad_lane_merge #(
   parameter int WORD_W = 64,
   localparam int BYTES = WORD_W / 8,
   localparam int NB_W  = $clog2(BYTES + 1)
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [NB_W-1:0]   keep_i,   // leading bytes kept, 0..BYTES
   output logic [WORD_W-1:0] word_o
);
   import sha512_pad_pkg::*;

   // Lane 0 is the most significant (earliest) byte of the word.
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      localparam int HI = WORD_W - 1 - 8 * b;
      always_comb begin
         if (NB_W'(b) < keep_i)       word_o[HI -: 8] = word_i[HI -: 8];
         else if (NB_W'(b) == keep_i) word_o[HI -: 8] = PAD_MARK;
         else                         word_o[HI -: 8] = 8'h00;
      end
   end

endmodule

// File: rtl/pad_block_reg.sv
module pad_block_reg #(
   parameter int WORD_W  = 64,
   parameter int BLOCK_W = 1024,
   localparam int WORDS  = BLOCK_W / WORD_W,
   localparam int IDX_W  = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [WORD_W-1:0]  wr_word,
   output logic [BLOCK_W-1:0] block_o
);

   // Word 0 occupies the top of the block.
   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (wr_en && wr_idx == IDX_W'(w))    q <= wr_word;
      end
      assign block_o[BLOCK_W-1-w*WORD_W -: WORD_W] = q;
   end

endmodule

// File: rtl/pad_ctrl.sv
module pad_ctrl #(
   parameter int WORD_W  = 64,
   parameter int BLOCK_W = 1024,
   parameter int LEN_W   = 128,
   parameter int CNT_W   = 64,
   localparam int BYTES     = WORD_W / 8,
   localparam int NB_W      = $clog2(BYTES + 1),
   localparam int WORDS     = BLOCK_W / WORD_W,
   localparam int IDX_W     = $clog2(WORDS),
   localparam int LEN_WORDS = LEN_W / WORD_W,
   localparam int LEN_IDX   = WORDS - LEN_WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_last,
   input  logic [NB_W-1:0]   nbytes_i,
   input  logic [WORD_W-1:0] merged_i,
   input  logic              out_ready,
   output logic              in_ready,
   output logic              out_valid,
   output logic              out_final,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [WORD_W-1:0] wr_word
);
   import sha512_pad_pkg::*;

   localparam logic [WORD_W-1:0] MARK_WORD = {PAD_MARK, {(WORD_W-8){1'b0}}};

   pad_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] bits_q;
   logic             mark_due_q;   // 0x80 not yet written
   logic             no_room_q;    // this block cannot carry the length
   logic             tail_q;       // message fully received
   logic             fin_q;

   logic             accept;
   logic             no_room_n;
   logic [LEN_W-1:0] len_field;
   logic [WORD_W-1:0] len_word;
   int               len_sel;

   assign accept    = (state_q == PS_FILL) && in_valid;
   assign in_ready  = (state_q == PS_FILL);
   assign out_valid = (state_q == PS_EMIT);
   assign out_final = (state_q == PS_EMIT) && fin_q;

   assign no_room_n = no_room_q || (mark_due_q && idx_q >= IDX_W'(LEN_IDX));
   assign len_field = LEN_W'(bits_q);
   assign len_sel   = (LEN_WORDS - 1 - (int'(idx_q) - LEN_IDX)) * WORD_W;
   assign len_word  = WORD_W'(len_field >> len_sel);

   always_comb begin
      wr_en   = 1'b0;
      wr_idx  = idx_q;
      wr_word = merged_i;
      if (accept) begin
         wr_en = 1'b1;
      end else if (state_q == PS_TAIL) begin
         wr_en = 1'b1;
         if (no_room_n || idx_q < IDX_W'(LEN_IDX))
            wr_word = mark_due_q ? MARK_WORD : '0;
         else
            wr_word = len_word;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PS_FILL;
         idx_q      <= '0;
         bits_q     <= '0;
         mark_due_q <= 1'b0;
         no_room_q  <= 1'b0;
         tail_q     <= 1'b0;
         fin_q      <= 1'b0;
      end else begin
         unique case (state_q)
            PS_FILL: if (accept) begin
               idx_q <= idx_q + 1'b1;
               if (in_last) begin
                  bits_q     <= bits_q + (CNT_W'(nbytes_i) << 3);
                  mark_due_q <= (nbytes_i == NB_W'(BYTES));
                  no_room_q  <= (idx_q >= IDX_W'(LEN_IDX));
                  tail_q     <= 1'b1;
               end else begin
                  bits_q <= bits_q + CNT_W'(WORD_W);
               end
               if (idx_q == IDX_W'(WORDS - 1)) begin
                  state_q <= PS_EMIT;
                  fin_q   <= 1'b0;
               end else if (in_last) begin
                  state_q <= PS_TAIL;
               end
            end
            PS_TAIL: begin
               idx_q      <= idx_q + 1'b1;
               mark_due_q <= 1'b0;
               no_room_q  <= no_room_n;
               if (idx_q == IDX_W'(WORDS - 1)) begin
                  state_q <= PS_EMIT;
                  fin_q   <= !no_room_n;
               end
            end
            PS_EMIT: if (out_ready) begin
               no_room_q <= 1'b0;
               if (fin_q) begin
                  state_q <= PS_FILL;
                  bits_q  <= '0;
                  tail_q  <= 1'b0;
                  fin_q   <= 1'b0;
               end else begin
                  state_q <= tail_q ? PS_TAIL : PS_FILL;
               end
            end
            default: state_q <= PS_FILL;
         endcase
      end
   end

endmodule

// File: rtl/sha512_pad_stream.sv
module sha512_pad_stream #(
   parameter int WORD_W  = 64,
   parameter int BLOCK_W = 1024,
   parameter int LEN_W   = 128,
   parameter int CNT_W   = 64,
   localparam int BYTES  = WORD_W / 8,
   localparam int NB_W   = $clog2(BYTES + 1),
   localparam int WORDS  = BLOCK_W / WORD_W,
   localparam int IDX_W  = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [WORD_W-1:0]  in_data,
   input  logic [NB_W-1:0]    in_bytes,
   input  logic               in_last,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [BLOCK_W-1:0] out_block,
   output logic               out_final
);

   if (WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
      $error("WORD_W must be a whole number of bytes, at least 16");
   end
   if (BLOCK_W % WORD_W != 0 || LEN_W % WORD_W != 0) begin : g_bad_split
      $error("BLOCK_W and LEN_W must be multiples of WORD_W");
   end
   if (LEN_W >= BLOCK_W || CNT_W >= LEN_W) begin : g_bad_len
      $error("need CNT_W < LEN_W < BLOCK_W");
   end

   logic [NB_W-1:0]   keep;
   logic [NB_W-1:0]   nb_clamp;
   logic [WORD_W-1:0] merged;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [WORD_W-1:0] wr_word;

   assign nb_clamp = (in_bytes > NB_W'(BYTES)) ? NB_W'(BYTES) : in_bytes;
   assign keep     = in_last ? nb_clamp : NB_W'(BYTES);

   pad_lane_merge #(.WORD_W(WORD_W)) i_merge (
      .word_i (in_data),
      .keep_i (keep),
      .word_o (merged)
   );

   pad_ctrl #(
      .WORD_W(WORD_W), .BLOCK_W(BLOCK_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .nbytes_i  (nb_clamp),
      .merged_i  (merged),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_final (out_final),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_word   (wr_word)
   );

   pad_block_reg #(.WORD_W(WORD_W), .BLOCK_W(BLOCK_W)) i_blk (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_word (wr_word),
      .block_o (out_block)
   );

endmodule

// File: rtl/sha512_pad_stream_chk.sv
module sha512_pad_stream_chk #(
   parameter int BLOCK_W = 1024,
   parameter int LEN_W   = 128,
   parameter int CNT_W   = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               in_last,
   input logic               out_valid,
   input logic               out_ready,
   input logic [BLOCK_W-1:0] out_block,
   input logic               out_final
);

   // R7: offered block holds under backpressure
   a_r7_hold_block: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_block) && $stable(out_final));

   // R8: no new word right after the last one is taken
   a_r8_busy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_last |=> !in_ready);

   // R8: input stalls while a block is offered
   a_r8_no_take_while_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R4: upper half of the length field is zero
   a_r4_len_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_final |-> out_block[LEN_W-1:CNT_W] == '0);

   // R6: final flag only with a valid block
   a_r6_final_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_final |-> out_valid);

   // R10: idle right after reset release
   a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !out_valid && in_ready);

endmodule

bind sha512_pad_stream sha512_pad_stream_chk #(
   .BLOCK_W(BLOCK_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_block (out_block),
   .out_final (out_final)
);

// File: tb/test_sha512_pad_stream.sv
module test_sha512_pad_stream;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [63:0]   in_data = '0;
   logic [3:0]    in_bytes = '0;
   logic          in_last = 1'b0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [1023:0] out_block;
   logic          out_final;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   sha512_pad_stream i_sha512_pad_stream (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_bytes(in_bytes), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_block(out_block), .out_final(out_final)
   );

   typedef struct packed {
      int len;    // message bytes
      int stall;  // cycles out_ready held low per block
      int nblk;   // expected block count
   } vec_t;

   localparam vec_t VECS[14] = '{
      '{0, 0, 1}, '{1, 2, 1}, '{7, 0, 1}, '{8, 0, 1},
      '{55, 3, 1}, '{111, 0, 1}, '{112, 2, 2}, '{119, 0, 2},
      '{120, 0, 2}, '{127, 1, 2}, '{128, 0, 2}, '{129, 0, 2},
      '{239, 0, 2}, '{240, 3, 3}
   };

   function automatic logic [7:0] msg_byte(int len, int i);
      return 8'((i * 29 + len * 7 + 3) & 255);
   endfunction

   // padded stream byte j of a message of len bytes spanning nblk blocks
   function automatic logic [7:0] exp_byte(int len, int nblk, int j);
      int total = nblk * 128;
      longint unsigned bits = longint'(len) * 8;
      if (j < len) return msg_byte(len, j);
      if (j == len) return 8'h80;
      if (j >= total - 8) return 8'(bits >> (8 * (total - 1 - j)));
      return 8'h00;
   endfunction

   task automatic check_blk(bit ok, string req, logic [1023:0] act, logic [1023:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_val(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_msg(int len);
      int nw = (len == 0) ? 1 : (len + 7) / 8;
      for (int w = 0; w < nw; w++) begin
         bit lst = (w == nw - 1);
         @(negedge clk);
         in_valid = 1'b1;
         in_last  = lst;
         in_bytes = lst ? 4'(len - 8 * w) : 4'd5;   // R9: junk count on non-last words
         for (int b = 0; b < 8; b++)
            in_data[63 - 8*b -: 8] = (8*w + b < len) ? msg_byte(len, 8*w + b) : 8'hA5;
         while (!in_ready) @(negedge clk);
         @(negedge clk);
         in_valid = 1'b0;
         in_last  = 1'b0;
         if (lst) check_val(in_ready == 1'b0, "R8 busy after last word", in_ready, 0);
      end
   endtask

   task automatic recv_msg(int len, int stall, int nblk);
      int got = 0;
      bit fin = 1'b0;
      while (!fin && got <= nblk) begin
         logic [1023:0] exp;
         logic [1023:0] snap;
         @(negedge clk);
         while (!out_valid) @(negedge clk);
         for (int k = 0; k < 128; k++)
            exp[1023 - 8*k -: 8] = exp_byte(len, nblk, got * 128 + k);
         // R1 R2 R3 R4 R5: full block content
         check_blk(out_block == exp, "R1/R2/R3/R4/R5 block content", out_block, exp);
         check_val(out_final == (got == nblk - 1), "R6 final flag", out_final, got == nblk - 1);
         snap = out_block;
         for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check_blk(out_valid && out_block == snap, "R7 held under stall", out_block, snap);
            check_val(in_ready == 1'b0, "R8 input stalled while offering", in_ready, 0);
         end
         fin = out_final;
         out_ready = 1'b1;
         @(negedge clk);
         out_ready = 1'b0;
         got++;
      end
      check_val(got == nblk, "R6 block count", got, nblk);
   endtask

   task automatic run_vec(vec_t v);
      fork
         send_msg(v.len);
         recv_msg(v.len, v.stall, v.nblk);
      join
      @(negedge clk);
      check_val(in_ready == 1'b1, "R8 ready after final handoff", in_ready, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_val(out_valid == 1'b0, "R10 no block in reset", out_valid, 0);
      check_val(in_ready == 1'b1, "R10 ready in reset", in_ready, 1);
      rst_n = 1'b1;

      foreach (VECS[i]) run_vec(VECS[i]);

      // R10: reset in the middle of a message discards it
      for (int w = 0; w < 3; w++) begin
         @(negedge clk);
         in_valid = 1'b1; in_last = 1'b0; in_bytes = 4'd8;
         in_data  = 64'hDEAD_BEEF_0123_4567;
      end
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check_val(out_valid == 1'b0, "R10 reset drops block", out_valid, 0);
      check_val(in_ready == 1'b1, "R10 reset raises ready", in_ready, 1);
      rst_n = 1'b1;
      run_vec('{5, 0, 1});

      // R9: count above 8 on the last word acts as 8
      fork
         begin
            @(negedge clk);
            in_valid = 1'b1; in_last = 1'b1; in_bytes = 4'd13;
            for (int b = 0; b < 8; b++) in_data[63 - 8*b -: 8] = msg_byte(8, b);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
         end
         recv_msg(8, 0, 1);
      join

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule